// File: doc/BRIEF.md
# Shared Display RAM Contention Arbiter

This block decides, on every CPU clock, whether a single RAM belongs to the display fetch engine or to the CPU. Time is split into an eight-slot cycle. A 3-bit phase taken from the horizontal counter selects the slot. Within each cycle the display side reads two bytes from the RAM, one CPU clock each: first the pixel byte, then the attribute byte. An output-latch strobe follows later in the cycle.

The CPU wait line is pulled low one clock before the display side takes the RAM, and it is released one clock after the display side hands the RAM back. This gives a CPU write that has already started time to complete before the RAM is taken away. While the display side owns the RAM, the write enable is held inactive by a plain OR gate. The read and chip-select lines are switched between the two masters; the write line is only gated.

Contention applies only while the beam is inside the active picture, or at all times when a test input is set. During a display byte fetch, an I/O read by the CPU sees the byte being read from the RAM. The block also delays the end-of-display marker so that it lines up with the late output-latch strobe.

Top module: `vid_cpu_arbiter`

## Requirements
- R1: With slot numbering `S = FIRST_SLOT` (default 1), `strobe_pix` is high only in phase S and `strobe_attr` only in phase S+1. Each is high for exactly one clock, and only in a contended cycle.
- R2: In a contended cycle, `vid_own` is high in phases S and S+1 only. `cpu_wait_n` is low in phases S-1 through S+2 whenever `cpu_bank` equals `REGION` (default 2'b01). The wait therefore starts one clock before ownership and ends one clock after it.
- R3: When `cpu_bank` differs from `REGION`, `cpu_wait_n` stays high in every phase.
- R4: While `vid_own` is high, `ram_we_n` is high whatever the CPU drives.
- R5: While `vid_own` is high, `ram_ce_n` and `ram_oe_n` are low. `vid_own` is also the RAM address mux select (1 = display address).
- R6: While `vid_own` is low, the RAM follows the CPU. Let sel = (!cpu_mreq_n && cpu_bank==REGION). Then `ram_ce_n` = !sel, `ram_oe_n` = !(sel && !cpu_rd_n), and `ram_we_n` = !(sel && !cpu_wr_n).
- R7: A cycle is contended when `disp_active | force_contend` is 1 in phase S-1. Later changes in those inputs during the same cycle have no effect.
- R8: `float_bus` equals `ram_rdata` while `strobe_pix` or `strobe_attr` is high, and 8'hFF otherwise.
- R9: `strobe_out` is high only in phase S+3 of a contended cycle.
- R10: `disp_end_dly` equals `disp_end` as it was `END_DLY` (default 4) clocks earlier, and it is 0 for the first `END_DLY` clocks after reset.
- R11: During reset, the strobes, `vid_own` and `disp_end_dly` are 0 and `cpu_wait_n` is 1, provided the contention inputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| hphase | input | 3 | Slot phase from the horizontal counter |
| disp_active | input | 1 | Beam inside the active picture |
| force_contend | input | 1 | Test input forcing contention on |
| disp_end | input | 1 | Raw end-of-display marker |
| cpu_bank | input | 2 | CPU address bits 15:14 |
| cpu_mreq_n | input | 1 | CPU memory request, active low |
| cpu_rd_n | input | 1 | CPU read, active low |
| cpu_wr_n | input | 1 | CPU write, active low |
| ram_rdata | input | 8 | Data currently read from the RAM |
| cpu_wait_n | output | 1 | Wait request to the CPU, active low |
| vid_own | output | 1 | Display side owns RAM; address mux select |
| strobe_pix | output | 1 | Pixel byte latch strobe |
| strobe_attr | output | 1 | Attribute byte latch strobe |
| strobe_out | output | 1 | Output latch strobe |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM read enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| float_bus | output | 8 | Floating-bus data seen by CPU I/O reads |
| disp_end_dly | output | 1 | Delayed end-of-display marker |

## Verification
The assertions assume that `hphase` advances by exactly one, modulo eight, on every clock after reset. Ownership edges are only ever checked against the wait window of a correctly sequenced cycle. The stimulus drives a free-running phase counter that never skips or repeats. It varies the contention inputs, address bank, CPU strobes and RAM data cycle by cycle with arithmetic patterns, so the captured contention decision is exercised against mid-cycle changes.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int PH_W  = 3;
  localparam int NSLOT = 1 << PH_W;

  // True when the one-hot slot vector has a bit set in [lo, hi].
  function automatic logic slot_in(input logic [NSLOT-1:0] oh, input int lo, input int hi);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NSLOT; i++)
      if (i >= lo && i <= hi) r = r | oh[i];
    return r;
  endfunction
endpackage

// File: rtl/slot_decoder.sv
module slot_decoder
  import arb_pkg::*;
(
  input  logic [PH_W-1:0]  phase,
  output logic [NSLOT-1:0] slot
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_dec
    assign slot[g] = (phase == PH_W'(g));
  end
endmodule

// File: rtl/ram_ctrl_gate.sv
module ram_ctrl_gate (
  input  logic vid_own,
  input  logic cpu_sel,
  input  logic cpu_rd_n,
  input  logic cpu_wr_n,
  output logic ram_ce_n,
  output logic ram_oe_n,
  output logic ram_we_n
);
  // Chip select and read are multiplexed; write is only gated off.
  assign ram_ce_n = vid_own ? 1'b0 : ~cpu_sel;
  assign ram_oe_n = vid_own ? 1'b0 : ~(cpu_sel & ~cpu_rd_n);
  assign ram_we_n = ~(cpu_sel & ~cpu_wr_n) | vid_own;
endmodule

// File: rtl/end_delay.sv
module end_delay #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] sh;
  if (DEPTH == 1) begin : g_one
    always_ff @(posedge clk)
      if (!rst_n) sh <= '0;
      else        sh <= din;
  end else begin : g_many
    always_ff @(posedge clk)
      if (!rst_n) sh <= '0;
      else        sh <= {sh[DEPTH-2:0], din};
  end
  assign dout = sh[DEPTH-1];
endmodule

// File: rtl/vid_cpu_arbiter.sv
module vid_cpu_arbiter
  import arb_pkg::*;
#(
  parameter int         FIRST_SLOT = 1,
  parameter int         END_DLY    = 4,
  parameter logic [1:0] REGION     = 2'b01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] hphase,
  input  logic            disp_active,
  input  logic            force_contend,
  input  logic            disp_end,
  input  logic [1:0]      cpu_bank,
  input  logic            cpu_mreq_n,
  input  logic            cpu_rd_n,
  input  logic            cpu_wr_n,
  input  logic [7:0]      ram_rdata,
  output logic            cpu_wait_n,
  output logic            vid_own,
  output logic            strobe_pix,
  output logic            strobe_attr,
  output logic            strobe_out,
  output logic            ram_ce_n,
  output logic            ram_oe_n,
  output logic            ram_we_n,
  output logic [7:0]      float_bus,
  output logic            disp_end_dly
);
  localparam int WAIT_SLOT = FIRST_SLOT - 1;
  localparam int ATTR_SLOT = FIRST_SLOT + 1;
  localparam int WAIT_END  = FIRST_SLOT + 2;
  localparam int OUT_SLOT  = FIRST_SLOT + 3;

  logic [NSLOT-1:0] slot;
  logic grp_q, grp_en, wait_win, in_region, cpu_sel;

  slot_decoder u_dec (.phase(hphase), .slot(slot));

  // Contention decision taken at the wait slot and held for the group.
  always_ff @(posedge clk)
    if (!rst_n)               grp_q <= 1'b0;
    else if (slot[WAIT_SLOT]) grp_q <= disp_active | force_contend;

  assign grp_en    = slot[WAIT_SLOT] ? (disp_active | force_contend) : grp_q;
  assign wait_win  = grp_en & slot_in(slot, WAIT_SLOT, WAIT_END);
  assign vid_own   = grp_en & slot_in(slot, FIRST_SLOT, ATTR_SLOT);
  assign in_region = (cpu_bank == REGION);
  assign cpu_sel   = ~cpu_mreq_n & in_region;

  assign cpu_wait_n  = ~(wait_win & in_region);
  assign strobe_pix  = grp_en & slot[FIRST_SLOT];
  assign strobe_attr = grp_en & slot[ATTR_SLOT];
  assign strobe_out  = grp_en & slot[OUT_SLOT];
  assign float_bus   = (strobe_pix | strobe_attr) ? ram_rdata : 8'hFF;

  ram_ctrl_gate u_gate (
    .vid_own (vid_own),
    .cpu_sel (cpu_sel),
    .cpu_rd_n(cpu_rd_n),
    .cpu_wr_n(cpu_wr_n),
    .ram_ce_n(ram_ce_n),
    .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n)
  );

  end_delay #(.DEPTH(END_DLY)) u_dly (
    .clk (clk),
    .rst_n(rst_n),
    .din (disp_end),
    .dout(disp_end_dly)
  );
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter logic [1:0] REGION = 2'b01
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cpu_bank,
  input logic       cpu_wait_n,
  input logic       vid_own,
  input logic       wait_win,
  input logic       grp_en,
  input logic       strobe_pix,
  input logic       strobe_attr,
  input logic       strobe_out,
  input logic       ram_ce_n,
  input logic       ram_oe_n,
  input logic       ram_we_n,
  input logic [7:0] ram_rdata,
  input logic [7:0] float_bus
);
  AST_WAIT_LEADS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vid_own) |-> $past(wait_win));                              // R2
  AST_WAIT_TRAILS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vid_own) |-> wait_win);                                     // R2
  AST_NO_WAIT_OFF_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_bank != REGION) |-> cpu_wait_n);                             // R3
  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    vid_own |-> ram_we_n);                                            // R4
  AST_VIDEO_READS: assert property (@(posedge clk) disable iff (!rst_n)
    vid_own |-> (!ram_ce_n && !ram_oe_n));                            // R5
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe_pix, strobe_attr, strobe_out}));                 // R1
  AST_OWN_NEEDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    vid_own |-> grp_en);                                              // R7
  AST_FLOAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_pix || strobe_attr) |-> (float_bus == 8'hFF));           // R8
  AST_FLOAT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_pix || strobe_attr) |-> (float_bus == ram_rdata));        // R8
endmodule

bind vid_cpu_arbiter arb_checker #(.REGION(REGION)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_bank(cpu_bank), .cpu_wait_n(cpu_wait_n),
  .vid_own(vid_own), .wait_win(wait_win), .grp_en(grp_en),
  .strobe_pix(strobe_pix), .strobe_attr(strobe_attr), .strobe_out(strobe_out),
  .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
  .ram_rdata(ram_rdata), .float_bus(float_bus)
);

// File: tb/tb_vid_cpu_arbiter.sv
module tb_vid_cpu_arbiter;
  localparam int         CLK_PERIOD = 10;
  localparam int         FS         = 1;
  localparam int         DLY        = 4;
  localparam logic [1:0] REG_BANK   = 2'b01;
  localparam int         NCYC       = 8 * 96;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hphase = '0;
  logic       disp_active = 1'b0, force_contend = 1'b0, disp_end = 1'b0;
  logic [1:0] cpu_bank = '0;
  logic       cpu_mreq_n = 1'b1, cpu_rd_n = 1'b1, cpu_wr_n = 1'b1;
  logic [7:0] ram_rdata = '0;
  logic       cpu_wait_n, vid_own, strobe_pix, strobe_attr, strobe_out;
  logic       ram_ce_n, ram_oe_n, ram_we_n, disp_end_dly;
  logic [7:0] float_bus;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_cpu_arbiter #(.FIRST_SLOT(FS), .END_DLY(DLY), .REGION(REG_BANK)) dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Bench model state
  logic           grp_m = 1'b0;
  logic [DLY-1:0] hist = '0;

  initial begin
    // R11: reset state
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      hphase = 3'(k);
      cpu_bank = REG_BANK;
      #1;
      check("R11 wait_n", {7'd0, cpu_wait_n}, 8'd1);
      check("R11 own/strobes", {4'd0, vid_own, strobe_pix, strobe_attr, strobe_out}, 8'd0);
      check("R11 dly", {7'd0, disp_end_dly}, 8'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    hphase = 3'd7;
    for (int i = 0; i < NCYC; i++) begin
      logic [2:0] ph;
      logic gnow, own, win, pix, att, outs, sel, inreg;
      int   g;
      @(negedge clk);
      ph = 3'(i % 8);
      g  = i / 8;
      hphase        = ph;
      disp_active   = ((i * 7 + g * 3) >> 2) % 2 == 1;
      force_contend = (g % 5) == 3;
      disp_end      = (i % 11) < 3;
      cpu_bank      = 2'((i / 3 + g) % 4);
      cpu_mreq_n    = (i % 5) == 0;
      cpu_rd_n      = (i % 3) != 1;
      cpu_wr_n      = (i % 3) != 2;
      ram_rdata     = 8'((i * 37 + 11) % 256);
      #1;
      gnow  = (ph == 3'(FS - 1)) ? (disp_active | force_contend) : grp_m;
      win   = gnow && (int'(ph) >= FS - 1) && (int'(ph) <= FS + 2);
      own   = gnow && (int'(ph) >= FS) && (int'(ph) <= FS + 1);
      pix   = gnow && (int'(ph) == FS);
      att   = gnow && (int'(ph) == FS + 1);
      outs  = gnow && (int'(ph) == FS + 3);
      inreg = (cpu_bank == REG_BANK);
      sel   = !cpu_mreq_n && inreg;
      check("R1 pix",  {7'd0, strobe_pix},  {7'd0, pix});
      check("R1 attr", {7'd0, strobe_attr}, {7'd0, att});
      check(inreg ? "R2 wait" : "R3 no wait", {7'd0, cpu_wait_n}, {7'd0, !(win && inreg)});
      check("R7 own", {7'd0, vid_own}, {7'd0, own});
      if (own) begin
        check("R4 we_n", {7'd0, ram_we_n}, 8'd1);
        check("R5 ce/oe", {6'd0, ram_ce_n, ram_oe_n}, 8'd0);
      end else begin
        check("R6 cpu path", {5'd0, ram_ce_n, ram_oe_n, ram_we_n},
              {5'd0, !sel, !(sel && !cpu_rd_n), !(sel && !cpu_wr_n)});
      end
      check("R8 float", float_bus, (pix || att) ? ram_rdata : 8'hFF);
      check("R9 out", {7'd0, strobe_out}, {7'd0, outs});
      check("R10 dly", {7'd0, disp_end_dly}, {7'd0, hist[DLY-1]});
      @(posedge clk);
      if (ph == 3'(FS - 1)) grp_m = disp_active | force_contend;
      hist = {hist[DLY-2:0], disp_end};
    end
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule